// File: doc/BRIEF.md
# Power Management Capability Register Block

This block holds the power management capability entry of a device's configuration space. It answers configuration reads at dword offsets and takes configuration writes with byte enables. The entry contains a capability identifier, a link to the next capability, a read-only word listing what the device supports, a control/status register and an 8-bit power report. The header's capability pointer dword is also served here, so the list can be found.

The device power state is kept in a small state machine with four named states: `PS_D0`, `PS_D1`, `PS_D2` and `PS_D3`. Every transition is a direct jump. A write of the power-state field moves the machine to the encoded state from any state. A normal reset returns it to `PS_D0`. The wake-enable and wake-status bits are sticky, so a normal reset does not touch them. A separate auxiliary reset input puts them into a known state instead. A wake event pulse sets the status bit. The active-low wake request output is driven low while both the enable bit and the status bit are 1.

A 4-bit report selector picks one entry of a fixed power-report table. It also sets the scale field that is read back with the selected entry.

Top module: `pm_regs`

## Requirements
- R1: Dword index 0x37 (byte 0xDC) reads capability ID 0x01 in bits [7:0] and next pointer 0x00 in bits [15:8]. Dword index 0x0D reads 0x000000DC, with the capability pointer in bits [7:0]. Any other index reads 0.
- R2: A write to dword 0x38 with byte enable 0 loads bits [1:0] into the power state (00 = D0, 01 = D1, 10 = D2, 11 = D3). The new state appears on `pwr_state` and in read bits [1:0] after the clock edge. A normal reset returns the state to D0.
- R3: A `wake_evt` pulse sets the status bit (dword 0x38, bit 15) on the next edge, whatever the value of the enable bit. A write with byte enable 1 and bit 15 = 1 clears the status bit. If a wake pulse and a clear come in the same cycle, the wake pulse wins.
- R4: `pme_n` is low exactly when the enable bit (bit 8) and the status bit (bit 15) are both 1.
- R5: `aux_rst` clears the status bit and sets the enable bit on the next edge. It takes priority over writes and wake pulses. A normal reset (`rst_n` low) leaves both bits unchanged.
- R6: The report selector is bits [12:9] and is writable through byte enable 1. The scale field (bits [14:13]) reads 2 when the selector is 0 to 8 and 0 when it is 9 to 15. A normal reset clears the selector.
- R7: The report field (bits [31:24]) reads 58 for selectors 0 and 4, 40 for selectors 1 to 3 and 5 to 7, and 0 for selectors 8 to 15.
- R8: The capabilities word (dword 0x37, bits [31:16]) has the following layout:
  - bits [2:0]: version 001;
  - bit 3: PME clock, 0;
  - bit 5: DSI, 1;
  - bits 9 and 10: D1 and D2 support, both 1;
  - bits [15:11]: PME support, 01111 when `aux_pwr` is 0 and 11111 when it is 1.
- R9: Bit 6 of the capabilities word follows `aux_pwr`.
- R10: The following bits always read 0, and writes to them have no effect:
  - PMCSR bits [7:2] and [23:16];
  - capabilities word bits 4, 7 and 8.

  Writes to dword 0x37 and to bits [31:24] of dword 0x38 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Normal reset, active low, synchronous |
| aux_rst | input | 1 | Auxiliary reset for the sticky wake bits, active high, synchronous |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Dword index into configuration space |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| wake_evt | input | 1 | Wake event pulse |
| aux_pwr | input | 1 | Auxiliary power present strap |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| pwr_state | output | 2 | Current power state |
| pme_n | output | 1 | Wake request, active low |

## Verification
The following are checked on every cycle:
- that `pme_n` agrees with the enable and status bits;
- that a wake pulse always sets status;
- that the auxiliary reset yields enable 1 and status 0;
- that a power-state write lands in `pwr_state`;
- that the scale field and the reserved read bits hold their values.

Some behaviour can only be shown by the bench's scenarios:
- that sticky bits survive a normal reset;
- that a wake pulse beats a clear in the same cycle;
- the full report table across all sixteen selectors;
- the capabilities word under both strap values.

// File: rtl/pm_regs_pkg.sv
package pm_regs_pkg;
    typedef enum logic [1:0] {
        PS_D0 = 2'b00,
        PS_D1 = 2'b01,
        PS_D2 = 2'b10,
        PS_D3 = 2'b11
    } pstate_e;

    localparam int ADDR_W      = 6;
    localparam int SEL_W       = 4;
    localparam int RPT_W       = 8;
    localparam logic [ADDR_W-1:0] HDR_PTR_DW = 6'h0D;
    localparam logic [ADDR_W-1:0] CAP_DW     = 6'h37;
    localparam logic [ADDR_W-1:0] CSR_DW     = 6'h38;
    localparam logic [7:0] CAP_ID   = 8'h01;
    localparam logic [7:0] CAP_BYTE = 8'hDC;
endpackage

// File: rtl/pm_state_fsm.sv
module pm_state_fsm
    import pm_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld,
    input  logic [1:0] ld_val,
    output logic [1:0] state_o
);
    pstate_e cur_q, nxt;

    always_comb begin
        nxt = cur_q;
        if (ld) begin
            unique case (ld_val)
                2'b00: nxt = PS_D0;
                2'b01: nxt = PS_D1;
                2'b10: nxt = PS_D2;
                2'b11: nxt = PS_D3;
                default: nxt = PS_D0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= PS_D0;
        else        cur_q <= nxt;
    end

    always_comb begin
        state_o = cur_q;
    end
endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl (
    input  logic clk,
    input  logic aux_rst,
    input  logic en_wr,
    input  logic en_val,
    input  logic clr,
    input  logic wake,
    output logic en_o,
    output logic sts_o
);
    logic en_q, sts_q;

    always_ff @(posedge clk) begin
        if (aux_rst) begin
            en_q  <= 1'b1;
            sts_q <= 1'b0;
        end else begin
            if (en_wr) en_q <= en_val;
            sts_q <= wake | (sts_q & ~clr);
        end
    end

    assign en_o  = en_q;
    assign sts_o = sts_q;
endmodule

// File: rtl/pm_report_table.sv
module pm_report_table
    import pm_regs_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int DW = RPT_W
) (
    input  logic [SW-1:0] sel,
    output logic [DW-1:0] value,
    output logic [1:0]    scale
);
    localparam int LAST_SCALED = 8;

    always_comb begin
        if (sel == 0 || sel == 4)  value = DW'(58);
        else if (sel < 8)          value = DW'(40);
        else                       value = '0;
        scale = (int'(sel) <= LAST_SCALED) ? 2'b10 : 2'b00;
    end
endmodule

// File: rtl/pm_regs.sv
module pm_regs
    import pm_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aux_rst,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    input  logic              wake_evt,
    input  logic              aux_pwr,
    output logic [31:0]       cfg_rdata,
    output logic [1:0]        pwr_state,
    output logic              pme_n
);
    logic             csr_wr, ps_ld, hi_wr;
    logic             en, sts;
    logic [SEL_W-1:0] sel_q;
    logic [RPT_W-1:0] rpt;
    logic [1:0]       scale;
    logic [15:0]      caps;

    assign csr_wr = rst_n && cfg_wr && (cfg_addr == CSR_DW);
    assign ps_ld  = csr_wr && cfg_be[0];
    assign hi_wr  = csr_wr && cfg_be[1];

    pm_state_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ld(ps_ld),
        .ld_val(cfg_wdata[1:0]), .state_o(pwr_state)
    );

    pm_wake_ctrl u_wake (
        .clk(clk), .aux_rst(aux_rst), .en_wr(hi_wr),
        .en_val(cfg_wdata[8]), .clr(hi_wr && cfg_wdata[15]),
        .wake(wake_evt), .en_o(en), .sts_o(sts)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)     sel_q <= '0;
        else if (hi_wr) sel_q <= cfg_wdata[12:9];
    end

    pm_report_table u_tab (.sel(sel_q), .value(rpt), .scale(scale));

    always_comb begin
        caps = {aux_pwr ? 5'b11111 : 5'b01111, 1'b1, 1'b1, 2'b00,
                aux_pwr, 1'b1, 1'b0, 1'b0, 3'b001};
    end

    always_comb begin
        unique case (cfg_addr)
            HDR_PTR_DW: cfg_rdata = {24'h0, CAP_BYTE};
            CAP_DW:     cfg_rdata = {caps, 8'h00, CAP_ID};
            CSR_DW:     cfg_rdata = {rpt, 8'h00, sts, scale, sel_q, en,
                                     6'b0, pwr_state};
            default:    cfg_rdata = '0;
        endcase
    end

    assign pme_n = ~(en & sts);
endmodule

// File: rtl/pm_regs_chk.sv
module pm_regs_chk
    import pm_regs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              aux_rst,
    input logic              cfg_wr,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [3:0]        cfg_be,
    input logic [31:0]       cfg_wdata,
    input logic              wake_evt,
    input logic [31:0]       cfg_rdata,
    input logic [1:0]        pwr_state,
    input logic              pme_n,
    input logic              en,
    input logic              sts,
    input logic [SEL_W-1:0]  sel_q,
    input logic [1:0]        scale
);
    a_r2_state_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == CSR_DW && cfg_be[0]) |=> pwr_state == $past(cfg_wdata[1:0]));
    a_r3_wake_sets: assert property (@(posedge clk) disable iff (!rst_n || aux_rst)
        wake_evt |=> sts);
    a_r4_pme_both: assert property (@(posedge clk) disable iff (!rst_n || aux_rst)
        !pme_n |-> (en && sts));
    a_r5_aux_reset: assert property (@(posedge clk) disable iff (!rst_n)
        aux_rst |=> (en && !sts && pme_n));
    a_r6_scale_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q > 4'd8) |-> scale == 2'b00);
    a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == CSR_DW) |-> (cfg_rdata[7:2] == 6'b0 && cfg_rdata[23:16] == 8'h0));
endmodule

bind pm_regs pm_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .aux_rst(aux_rst), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .wake_evt(wake_evt), .cfg_rdata(cfg_rdata), .pwr_state(pwr_state),
    .pme_n(pme_n), .en(en), .sts(sts), .sel_q(sel_q), .scale(scale)
);

// File: tb/pm_regs_bench.sv
module pm_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, aux_rst = 1'b1, cfg_wr = 1'b0, wake_evt = 1'b0, aux_pwr = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic [1:0]  pwr_state;
    logic        pme_n;
    int          n_run = 0, n_fail = 0;
    logic [1:0]  m_ps;
    logic        m_en, m_st;
    logic [3:0]  m_sel;

    always #5 clk = ~clk;

    pm_regs u_pm_regs (
        .clk(clk), .rst_n(rst_n), .aux_rst(aux_rst), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .wake_evt(wake_evt), .aux_pwr(aux_pwr), .cfg_rdata(cfg_rdata),
        .pwr_state(pwr_state), .pme_n(pme_n)
    );

    function automatic logic [7:0] exp_rpt(input logic [3:0] s);
        if (s == 0 || s == 4) return 8'd58;
        if (s < 8) return 8'd40;
        return 8'd0;
    endfunction

    function automatic logic [31:0] exp_csr();
        return {exp_rpt(m_sel), 8'h00, m_st, (m_sel <= 8) ? 2'b10 : 2'b00,
                m_sel, m_en, 6'b0, m_ps};
    endfunction

    function automatic logic [31:0] exp_cap(input logic a);
        return {a ? 5'b11111 : 5'b01111, 2'b11, 2'b00, a, 1'b1, 2'b00, 3'b001,
                8'h00, 8'h01};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock with given stimulus; model updated on the same edge
    task automatic step(input logic wr, input logic [5:0] a, input logic [3:0] be,
                        input logic [31:0] wd, input logic wk, input logic ar, input logic rn);
        @(negedge clk);
        cfg_wr = wr; cfg_addr = a; cfg_be = be; cfg_wdata = wd;
        wake_evt = wk; aux_rst = ar; rst_n = rn;
        @(posedge clk);
        if (!rn) begin m_ps = 2'b00; m_sel = 4'd0; end
        else if (wr && a == 6'h38) begin
            if (be[0]) m_ps = wd[1:0];
            if (be[1]) m_sel = wd[12:9];
        end
        if (ar) begin m_en = 1'b1; m_st = 1'b0; end
        else begin
            if (rn && wr && a == 6'h38 && be[1]) begin
                m_en = wd[8];
                m_st = wk | (m_st & ~wd[15]);
            end else m_st = wk | m_st;
        end
        @(negedge clk);
        cfg_wr = 1'b0; wake_evt = 1'b0; aux_rst = 1'b0; rst_n = 1'b1;
    endtask

    task automatic check_csr(input string req);
        cfg_addr = 6'h38; #1;
        check(req, cfg_rdata, exp_csr());
        check({req, " pins"}, {29'b0, pwr_state, pme_n}, {29'b0, m_ps, ~(m_en & m_st)});
    endtask

    initial begin
        #2_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_ps = 0; m_sel = 0; m_en = 1; m_st = 0;
        step(0, 0, 0, 0, 0, 1, 0);
        check_csr("R5 R2 reset state");
        cfg_addr = 6'h37; #1; check("R1 R8 R9 cap aux0", cfg_rdata, exp_cap(1'b0));
        aux_pwr = 1'b1; #1; check("R8 R9 cap aux1", cfg_rdata, exp_cap(1'b1));
        cfg_addr = 6'h0D; #1; check("R1 header ptr", cfg_rdata, 32'h000000DC);
        cfg_addr = 6'h20; #1; check("R1 other index", cfg_rdata, 32'h0);
        // R3 wake sets status with enable off
        step(1, 6'h38, 4'b0010, 32'h0, 0, 0, 1);
        step(0, 0, 0, 0, 1, 0, 1);
        check_csr("R3 wake with enable off");
        // R4 enable -> pme asserted
        step(1, 6'h38, 4'b0010, 32'h100, 0, 0, 1);
        check_csr("R4 pme asserted");
        // R5 normal reset keeps sticky bits
        step(0, 0, 0, 0, 0, 0, 0);
        check_csr("R5 sticky across reset");
        // R3 wake beats clear
        step(1, 6'h38, 4'b0010, 32'h8100, 1, 0, 1);
        check_csr("R3 wake beats clear");
        step(1, 6'h38, 4'b0010, 32'h8100, 0, 0, 1);
        check_csr("R3 clear");
        // R5 aux reset beats write and wake
        step(1, 6'h38, 4'b0010, 32'h0000, 1, 1, 1);
        check_csr("R5 aux reset priority");
        // R6 R7 all selectors
        for (int s = 0; s < 16; s++) begin
            step(1, 6'h38, 4'b0010, 32'h100 | (s << 9), 0, 0, 1);
            check_csr("R6 R7 selector sweep");
        end
        // R2 all states
        for (int p = 0; p < 4; p++) begin
            step(1, 6'h38, 4'b0001, 32'hFFFF_FFFC | p, 0, 0, 1);
            check_csr("R2 R10 state write");
        end
        // R10 writes to capability dword ignored
        step(1, 6'h37, 4'b1111, 32'hFFFF_FFFF, 0, 0, 1);
        cfg_addr = 6'h37; #1; check("R10 cap write ignored", cfg_rdata, exp_cap(aux_pwr));
        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [31:0] wd;
            wd = $urandom;
            aux_pwr = 1'($urandom);
            step(($urandom % 3) != 0, ($urandom % 4 == 0) ? 6'h37 : 6'h38, 4'($urandom),
                 wd, ($urandom % 5) == 0, ($urandom % 40) == 0, ($urandom % 30) != 0);
            check_csr("R2 R3 R4 R5 R6 R7 R10 random");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule